// File: doc/BRIEF.md
# Multi-Mode Down-Counter Timer Channel

This block is one timer channel built around a down counter (16 bits by default). A host programs a reload value one byte at a time and then writes an 8-bit control word. The control word picks the counting mode, the gate polarity, whether a timeout raises the interrupt, whether the counter runs, whether the readback copy is frozen, and whether the reload value is to be loaded. The channel drives a timer output together with its complement, a sticky interrupt line, and a readback copy of the counter.

Four counting behaviours are provided: a single timeout, a repeating one-clock strobe, a retriggerable one-shot started by a gate edge, and a rate generator. All state advances on the rising edge of `clk`, which is the count clock. Host writes arrive as single-cycle strobes that have already been synchronised to this clock.

Top module: `tmr_channel`

## Requirements
- R1: While `rst_n` is low at a clock edge, the channel clears its state. `tmr_o` goes to 0, `tmr_n_o` to 1, `irq_o` to 0 and `hold_o` to 0. The stored control word becomes 0 and the counter stops.
- R2: The counter takes at most one step per clock, and only when control bit 5 (run) is 1. In modes 1, 2 and 4 the gate must also be at its valid level: high when control bit 3 is 1, low when it is 0. A cycle with a control write takes no step.
- R3: A control write whose mode field (bits 2:0) is nonzero, or whose bit 7 is 1, drives `tmr_o` to 0 on the next clock. A mode field of 000 keeps the stored mode. With mode codes 5, 6 and 7 the counter neither loads nor counts.
- R4: A control write with bit 7 = 1 arms a reload. The reload happens at the first later clock at which run is set, the mode is 1 to 4 and the gate is valid (mode 3 does not need the gate). At that clock the counter takes the reload value and `tmr_o` goes to 1.
- R5: In mode 1 (code 001), the step that brings the counter to 0 drives `tmr_o` to 0. The next enabled step sets the counter to all ones, and it then stays there until a reload.
- R6: In mode 2 (code 010) and mode 4 (code 100), the step that reaches 0 drives `tmr_o` low for exactly one enabled step. The next step reloads the counter from the reload register, sets `tmr_o` high, and the cycle repeats.
- R7: In mode 3 (code 011), a gate transition into the valid level loads the counter and sets `tmr_o` high, even while a count is in progress. The count then runs whatever the gate level, and ends as in mode 1.
- R8: When a step reaches 0 while control bit 4 is 1, `irq_o` goes to 1. It stays at 1 until the next control write clears it. With bit 4 = 0, reaching 0 leaves `irq_o` unchanged.
- R9: `hold_o` shows the counter value one clock late while control bit 6 is 0. While bit 6 is 1, `hold_o` is frozen. Each control write with bit 6 = 1 captures the counter once, on the following clock.
- R10: A reload-register byte write (`jam_sel_i` = 1 writes bits 15:8, 0 writes bits 7:0) does not change the counter. The new value is used only at the next reload.
- R11: A control write with bit 7 = 1 and mode field 000 reloads the counter from the reload register and keeps the current mode.
- R12: `tmr_n_o` is always the inverse of `tmr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_i | input | 1 | Gate input: its level enables counting, its edge triggers mode 3 |
| jam_wr_i | input | 1 | Single-cycle strobe that writes one byte of the reload register |
| jam_sel_i | input | 1 | Byte select for the reload write (1 = bits 15:8) |
| jam_byte_i | input | 8 | Reload byte data |
| ctl_wr_i | input | 1 | Single-cycle control-word write strobe |
| ctl_data_i | input | 8 | Control word: 7 jam enable, 6 freeze, 5 run, 4 irq enable, 3 gate high, 2:0 mode |
| tmr_o | output | 1 | Timer output |
| tmr_n_o | output | 1 | Complement of the timer output |
| irq_o | output | 1 | Sticky timeout interrupt, active high |
| hold_o | output | 16 | Holding-register readback of the counter |

## Verification
Each mode is run with the gate held steady, with the gate dropping in the middle of a count, and with the run bit cleared and set again. This separates the level-gated stalls of modes 1, 2 and 4 from the edge start of mode 3. In mode 3, a retrigger during a count and a start armed by bit 7 with no gate edge show whether a reload comes from an edge or from the armed flag. The reload register is rewritten in the middle of a count in modes 1 and 2: the counter must not change until the next reload. Freeze, refresh and tracking writes, together with mode codes 000, 101, 110 and 111, expose any mix-up between capturing the readback copy, keeping the mode, and idling the counter.

// File: rtl/tmr_pkg.sv
// Shared types for the timer channel: control-word layout and mode codes.
// Assumes an 8-bit control word; the bit order is fixed because the host
// encodes it.
package tmr_pkg;

    typedef enum logic [2:0] {
        MODE_NONE    = 3'd0,
        MODE_TIMEOUT = 3'd1,
        MODE_STROBE  = 3'd2,
        MODE_ONESHOT = 3'd3,
        MODE_RATE    = 3'd4,
        MODE_VDC     = 3'd5,
        MODE_RSV     = 3'd6,
        MODE_VDC_ALT = 3'd7
    } tmr_mode_e;

    typedef struct packed {
        logic      jam_en;
        logic      hold_frz;
        logic      run;
        logic      irq_en;
        logic      gate_hi;
        tmr_mode_e mode;
    } tmr_ctl_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/tmr_ctl_reg.sv
// Control and reload storage for one timer channel.
// Holds the stored control fields, the reload (jam) register written a byte
// at a time, the armed-reload flag and the one-shot readback refresh flag.
// Assumes the host strobes are single-cycle and synchronous to clk.
module tmr_ctl_reg
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int NBYTES = CNT_W / BYTE_W,
    localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_i,
    input  tmr_ctl_t          ctl_data_i,
    input  logic              jam_wr_i,
    input  logic [SEL_W-1:0]  jam_sel_i,
    input  logic [BYTE_W-1:0] jam_byte_i,
    input  logic              load_ack_i,
    output tmr_mode_e         mode_o,
    output logic              gate_hi_o,
    output logic              irq_en_o,
    output logic              run_o,
    output logic              frz_o,
    output logic [CNT_W-1:0]  jam_o,
    output logic              pend_o,
    output logic              refresh_o
);

    tmr_mode_e mode_q;
    logic      gate_hi_q, irq_en_q, run_q, frz_q, pend_q, refresh_q;

    // Latch control fields; a zero mode field keeps the stored mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_NONE;
            gate_hi_q <= 1'b0;
            irq_en_q  <= 1'b0;
            run_q     <= 1'b0;
            frz_q     <= 1'b0;
        end else if (ctl_wr_i) begin
            if (ctl_data_i.mode != MODE_NONE) mode_q <= ctl_data_i.mode;
            gate_hi_q <= ctl_data_i.gate_hi;
            irq_en_q  <= ctl_data_i.irq_en;
            run_q     <= ctl_data_i.run;
            frz_q     <= ctl_data_i.hold_frz;
        end
    end

    // Armed-reload flag: set by a jam-enabled write, cleared once consumed.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (ctl_wr_i)   pend_q <= ctl_data_i.jam_en;
        else if (load_ack_i) pend_q <= 1'b0;
    end

    // One-cycle refresh request for the frozen readback copy.
    always_ff @(posedge clk) begin
        if (!rst_n) refresh_q <= 1'b0;
        else        refresh_q <= ctl_wr_i && ctl_data_i.hold_frz;
    end

    // Reload register, one byte lane per generate slice.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        // Byte lane write from the host.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q <= '0;
            else if (jam_wr_i && (jam_sel_i == SEL_W'(b)))
                lane_q <= jam_byte_i;
        end
        assign jam_o[b*BYTE_W +: BYTE_W] = lane_q;
    end

    assign mode_o    = mode_q;
    assign gate_hi_o = gate_hi_q;
    assign irq_en_o  = irq_en_q;
    assign run_o     = run_q;
    assign frz_o     = frz_q;
    assign pend_o    = pend_q;
    assign refresh_o = refresh_q;

    // R4
    arm_on_jam_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && ctl_data_i.jam_en) |=> pend_q);

endmodule

// File: rtl/tmr_core.sv
// Counting engine: down counter, timer output and sticky interrupt.
// Modes 1-4 count; other mode codes leave the counter idle.
// A reaching-zero step is followed by one more enabled step that either
// reloads (modes 2, 4) or parks the counter at all ones (modes 1, 3).
// Assumes a control write cycle takes no counting step.
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_i,
    input  tmr_mode_e        mode_i,
    input  logic             gate_hi_i,
    input  logic             irq_en_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] jam_i,
    input  logic             pend_i,
    input  logic             ctl_wr_i,
    input  logic             out_clr_i,
    output logic             load_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             out_o,
    output logic             irq_o
);

    logic [CNT_W-1:0] cnt_q, cnt_dec;
    logic             out_q, irq_q, active_q, wrap_q, gprev_q;
    logic             counting_mode, oneshot, rearm, gate_ok, gate_edge;
    logic             live, load, retrig, step_en;

    // Decode mode class and gate qualification for this cycle.
    always_comb begin
        counting_mode = (mode_i == MODE_TIMEOUT) || (mode_i == MODE_STROBE) ||
                        (mode_i == MODE_ONESHOT) || (mode_i == MODE_RATE);
        oneshot   = (mode_i == MODE_ONESHOT);
        rearm     = (mode_i == MODE_STROBE) || (mode_i == MODE_RATE);
        gate_ok   = (gate_i == gate_hi_i);
        gate_edge = gate_ok && (gprev_q != gate_hi_i);
        live      = !ctl_wr_i && run_i && counting_mode;
        load      = live && pend_i && (oneshot || gate_ok);
        retrig    = live && oneshot && gate_edge && !load;
        step_en   = live && active_q && (oneshot || gate_ok) && !load && !retrig;
        cnt_dec   = cnt_q - 1'b1;
    end

    // Counter, output level, activity and interrupt state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            out_q    <= 1'b0;
            irq_q    <= 1'b0;
            active_q <= 1'b0;
            wrap_q   <= 1'b0;
        end else if (ctl_wr_i) begin
            irq_q <= 1'b0;
            if (out_clr_i) out_q <= 1'b0;
        end else if (load || retrig) begin
            cnt_q    <= jam_i;
            out_q    <= 1'b1;
            active_q <= 1'b1;
            wrap_q   <= 1'b0;
        end else if (step_en) begin
            if (wrap_q) begin
                wrap_q <= 1'b0;
                if (rearm) begin
                    cnt_q <= jam_i;
                    out_q <= 1'b1;
                end else begin
                    cnt_q    <= '1;
                    active_q <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_dec;
                if (cnt_dec == '0) begin
                    out_q  <= 1'b0;
                    wrap_q <= 1'b1;
                    if (irq_en_i) irq_q <= 1'b1;
                end
            end
        end
    end

    // Previous gate level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) gprev_q <= 1'b0;
        else        gprev_q <= gate_i;
    end

    assign load_o = load;
    assign cnt_o  = cnt_q;
    assign out_o  = out_q;
    assign irq_o  = irq_q;

    // R2
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !ctl_wr_i) |=> $stable(cnt_q));

    // R3
    out_low_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_clr_i |=> !out_q);

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_i |=> !irq_q);

    // R4
    load_sets_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (out_q && cnt_q == $past(jam_i)));

endmodule

// File: rtl/tmr_hold.sv
// Readback holding register. Tracks the counter one clock late unless
// frozen; a refresh request captures one fresh value while frozen.
module tmr_hold #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             frz_i,
    input  logic             refresh_i,
    output logic [CNT_W-1:0] hold_o
);

    logic [CNT_W-1:0] hold_q;

    // Capture the counter when tracking or on a refresh request.
    always_ff @(posedge clk) begin
        if (!rst_n)                  hold_q <= '0;
        else if (!frz_i || refresh_i) hold_q <= cnt_i;
    end

    assign hold_o = hold_q;

    // R9
    frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_i && !refresh_i) |=> $stable(hold_q));

endmodule

// File: rtl/tmr_channel.sv
// Top of one timer channel: control storage, counting engine and readback.
// Assumes host writes are already synchronous single-cycle strobes.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int NBYTES = CNT_W / BYTE_W,
    localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_i,
    input  logic              jam_wr_i,
    input  logic [SEL_W-1:0]  jam_sel_i,
    input  logic [BYTE_W-1:0] jam_byte_i,
    input  logic              ctl_wr_i,
    input  logic [BYTE_W-1:0] ctl_data_i,
    output logic              tmr_o,
    output logic              tmr_n_o,
    output logic              irq_o,
    output logic [CNT_W-1:0]  hold_o
);

    tmr_ctl_t         wr_word;
    tmr_mode_e        mode;
    logic             gate_hi, irq_en, run, frz, pend, refresh, load, out_clr, out;
    logic [CNT_W-1:0] jam, cnt;

    assign wr_word = tmr_ctl_t'(ctl_data_i);
    assign out_clr = ctl_wr_i && ((wr_word.mode != MODE_NONE) || wr_word.jam_en);

    tmr_ctl_reg #(.CNT_W(CNT_W)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_i(ctl_wr_i), .ctl_data_i(wr_word),
        .jam_wr_i(jam_wr_i), .jam_sel_i(jam_sel_i), .jam_byte_i(jam_byte_i),
        .load_ack_i(load),
        .mode_o(mode), .gate_hi_o(gate_hi), .irq_en_o(irq_en), .run_o(run),
        .frz_o(frz), .jam_o(jam), .pend_o(pend), .refresh_o(refresh)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .gate_i(gate_i),
        .mode_i(mode), .gate_hi_i(gate_hi), .irq_en_i(irq_en), .run_i(run),
        .jam_i(jam), .pend_i(pend), .ctl_wr_i(ctl_wr_i), .out_clr_i(out_clr),
        .load_o(load), .cnt_o(cnt), .out_o(out), .irq_o(irq_o)
    );

    tmr_hold #(.CNT_W(CNT_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt),
        .frz_i(frz), .refresh_i(refresh), .hold_o(hold_o)
    );

    assign tmr_o   = out;
    assign tmr_n_o = ~out;

endmodule

// File: tb/tmr_channel_test.sv
`timescale 1ns/1ps
module tmr_channel_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gate = 1'b0;
    logic       jam_wr = 1'b0;
    logic [0:0] jam_sel = 1'b0;
    logic [7:0] jam_byte = 8'h00;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_data = 8'h00;
    logic       tmr, tmr_n, irq;
    logic [15:0] hold;

    int checks = 0;
    int fails = 0;
    bit cmp_en = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    tmr_channel uut (
        .clk(clk), .rst_n(rst_n), .gate_i(gate),
        .jam_wr_i(jam_wr), .jam_sel_i(jam_sel), .jam_byte_i(jam_byte),
        .ctl_wr_i(ctl_wr), .ctl_data_i(ctl_data),
        .tmr_o(tmr), .tmr_n_o(tmr_n), .irq_o(irq), .hold_o(hold)
    );

    // Behavioural reference model, written from the requirements.
    int m_mode, m_cnt, m_jam, m_hold;
    bit m_gate_hi, m_ien, m_run, m_frz;
    bit m_out, m_irq, m_pend, m_ref, m_act, m_wrap, m_gprev;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_jam = 0; m_hold = 0;
            m_gate_hi = 0; m_ien = 0; m_run = 0; m_frz = 0;
            m_out = 0; m_irq = 0; m_pend = 0; m_ref = 0;
            m_act = 0; m_wrap = 0; m_gprev = 0;
        end else begin
            int  next_hold;
            bit  next_ref, ok, edge_seen, one, legal;
            next_hold = (!m_frz || m_ref) ? m_cnt : m_hold;
            next_ref  = ctl_wr && ctl_data[6];
            if (ctl_wr) begin
                m_irq = 0;
                if (ctl_data[2:0] != 0 || ctl_data[7]) m_out = 0;
                if (ctl_data[2:0] != 0) m_mode = ctl_data[2:0];
                m_gate_hi = ctl_data[3];
                m_ien = ctl_data[4];
                m_run = ctl_data[5];
                m_frz = ctl_data[6];
                m_pend = ctl_data[7];
            end else begin
                legal = (m_mode >= 1) && (m_mode <= 4);
                one = (m_mode == 3);
                ok = (gate == m_gate_hi);
                edge_seen = ok && (m_gprev != m_gate_hi);
                if (m_run && legal) begin
                    if ((m_pend && (one || ok)) || (one && edge_seen)) begin
                        if (m_pend && (one || ok)) m_pend = 0;
                        m_cnt = m_jam; m_out = 1; m_act = 1; m_wrap = 0;
                    end else if (m_act && (one || ok)) begin
                        if (m_wrap) begin
                            m_wrap = 0;
                            if (m_mode == 2 || m_mode == 4) begin
                                m_cnt = m_jam; m_out = 1;
                            end else begin
                                m_cnt = 16'hFFFF; m_act = 0;
                            end
                        end else begin
                            m_cnt = (m_cnt + 65535) % 65536;
                            if (m_cnt == 0) begin
                                m_out = 0; m_wrap = 1;
                                if (m_ien) m_irq = 1;
                            end
                        end
                    end
                end
            end
            if (jam_wr) begin
                if (jam_sel[0]) m_jam = (m_jam & 'h00FF) | (int'(jam_byte) << 8);
                else            m_jam = (m_jam & 'hFF00) | int'(jam_byte);
            end
            m_hold = next_hold;
            m_ref = next_ref;
            m_gprev = gate;
        end
    end

    task automatic chk(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(int'(tmr), int'(m_out), cur_req, "tmr_o");
            chk(int'(tmr_n), int'(!tmr), "R12", "tmr_n_o");
            chk(int'(irq), int'(m_irq), cur_req, "irq_o");
            chk(int'(hold), m_hold, cur_req, "hold_o");
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl(input logic [7:0] v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_data = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic jamw(input int v);
        @(negedge clk);
        jam_wr = 1'b1; jam_sel = 1'b0; jam_byte = 8'(v);
        @(negedge clk);
        jam_sel = 1'b1; jam_byte = 8'(v >> 8);
        @(negedge clk);
        jam_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait_cyc(3);
        // R1: reset values at the ports
        chk(int'(tmr), 0, "R1", "reset tmr_o");
        chk(int'(tmr_n), 1, "R1", "reset tmr_n_o");
        chk(int'(irq), 0, "R1", "reset irq_o");
        chk(int'(hold), 0, "R1", "reset hold_o");
        cmp_en = 1'b1;
        rst_n = 1'b1;
        wait_cyc(2);

        cur_req = "R4"; jamw(5); ctl(8'hB9); wait_cyc(4);
        cur_req = "R2"; gate = 1; wait_cyc(3); gate = 0; wait_cyc(3); gate = 1;
        cur_req = "R5"; wait_cyc(12);
        cur_req = "R8"; ctl(8'h39); wait_cyc(3);
        cur_req = "R10"; jamw(3); wait_cyc(3);
        cur_req = "R6"; ctl(8'hAA); wait_cyc(6); jamw(2); wait_cyc(12);
        cur_req = "R9"; ctl(8'h6A); wait_cyc(5); ctl(8'h6A); wait_cyc(5); ctl(8'h2A); wait_cyc(4);
        cur_req = "R2"; ctl(8'h0A); wait_cyc(5); ctl(8'h2A); wait_cyc(5);
        cur_req = "R11"; ctl(8'hA8); wait_cyc(8);
        cur_req = "R6"; ctl(8'hBC); wait_cyc(10);
        cur_req = "R3"; ctl(8'hAF); wait_cyc(5); ctl(8'hAE); wait_cyc(3);
        cur_req = "R7"; gate = 0; jamw(4); ctl(8'h3B); wait_cyc(3);
        gate = 1; wait_cyc(2); gate = 0; wait_cyc(1); gate = 1; wait_cyc(10);
        ctl(8'hBB); wait_cyc(8);
        cur_req = "R2"; gate = 0; jamw(3); ctl(8'hB1); wait_cyc(3);
        gate = 1; wait_cyc(3); gate = 0; wait_cyc(6);

        cmp_en = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule